// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block takes divide-ratio words from a three-wire serial link (serial clock, serial data, latch strobe) and holds them for a frequency synthesizer's two dividers. One holding register feeds the reference divider. The other feeds the feedback divider, which is split into a swallow count and a main count.

Every bit first enters a one-bit selector register. The bit that was already in the selector moves on into a shared ratio shift register. The bit sent last in a frame is therefore the selector. At the rising edge of the latch strobe, the selector picks which holding register takes the shifted ratio. Only that register updates.

All three serial wires are assumed to be already synchronous to the system clock `clk`. The block finds their rising edges by comparing each wire with its value one cycle earlier. A ready flag for each divider shows that the divider has been written at least once since reset.

Top module: `serial_ratio_loader`

## Requirements
- R1: While `rst` is high at a `clk` edge, after that edge `ref_ratio`, `swallow_cnt` and `main_cnt` are zero, and `ref_ready` and `fb_ready` are low.
- R2: A shift happens on a `clk` edge where `ser_clk` is 1 and was 0 at the previous edge. On a shift, `ser_data` enters the selector, and the old selector value enters bit 0 of the 18-bit ratio register, whose bits move up by one. Nothing shifts while `ser_clk` stays high or when it falls.
- R3: If the selector is 0 at a latch event, the feedback holding register loads the ratio register. Ratio bits 17..12 go to `swallow_cnt` and bits 11..0 go to `main_cnt`. A frame is 6 swallow bits MSB first, then 12 main bits MSB first, then a selector of 0. `ref_ratio` keeps its value.
- R4: If the selector is 1 at a latch event, `ref_ratio` loads ratio bits 13..0. A frame is 14 bits MSB first, then a selector of 1. `swallow_cnt` and `main_cnt` keep their values.
- R5: `ref_ready` and `fb_ready` go high after that divider's first latch event and then stay high until reset. Writing one divider leaves the other divider's flag unchanged.
- R6: A frame may carry any number of extra leading bits. Only the last 19 bits shifted (15 bits for a reference frame) decide what is latched.
- R7: A latch event is a rising edge of `ser_le`. Holding `ser_le` high causes no further loads, even while new bits are shifted in.
- R8: All outputs keep their values between latch events, however many bits are shifted.
- R9: If a shift and a latch event fall on the same `clk` edge, the latch takes the register contents from before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock; shifts on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Latch strobe; loads on its rising edge |
| ref_ratio | output | 14 | Reference divider ratio |
| swallow_cnt | output | 6 | Feedback swallow count |
| main_cnt | output | 12 | Feedback main count |
| ref_ready | output | 1 | Reference ratio written since reset |
| fb_ready | output | 1 | Feedback ratio written since reset |

## Verification
Frames of random length shift extra bits out ahead of the real frame. A design that kept the first bits received, rather than the last, would latch the wrong fields.

Some directed cases hold the strobe high while a new frame is shifted in. A level-triggered latch would pass the new bits straight to the outputs.

Another case puts a shift and a strobe edge on the same cycle. A design that latched after shifting would be off by one bit.

A write to one divider is followed by a check of the other divider's outputs and ready flag. Steering that does not depend on the selector would show up there.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
    localparam int SWALLOW_W = 6;
    localparam int MAIN_W    = 12;
    localparam int REF_W     = 14;
    localparam int FB_W      = SWALLOW_W + MAIN_W;

    typedef struct packed {
        logic [SWALLOW_W-1:0] swallow;
        logic [MAIN_W-1:0]    main;
    } fb_word_t;

    function automatic fb_word_t split_fb(input logic [FB_W-1:0] raw);
        fb_word_t w;
        w.swallow = raw[FB_W-1 -: SWALLOW_W];
        w.main    = raw[MAIN_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/rise_det.sv
module rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign pulse = lvl & ~lvl_q;

    AST_PULSE_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R7
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] ratio_sr,
    output logic         sel_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_sr <= '0;
            sel_bit  <= 1'b0;
        end else if (shift) begin
            sel_bit  <= din;
            ratio_sr <= {ratio_sr[W-2:0], sel_bit};
        end
    end

    AST_SEL_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
        shift |=> sel_bit == $past(din)); // R2
    AST_CHAIN_MOVES: assert property (@(posedge clk) disable iff (rst)
        shift |=> ratio_sr[0] == $past(sel_bit)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(ratio_sr) && $stable(sel_bit)); // R2
endmodule

// File: rtl/ratio_hold.sv
module ratio_hold #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            ready <= 1'b0;
        end else if (load) begin
            q     <= d;
            ready <= 1'b1;
        end
    end

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R8
    AST_READY_SETS: assert property (@(posedge clk) disable iff (rst)
        load |=> ready); // R5
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R5
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader
    import ratio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_le,
    output logic [REF_W-1:0]     ref_ratio,
    output logic [SWALLOW_W-1:0] swallow_cnt,
    output logic [MAIN_W-1:0]    main_cnt,
    output logic                 ref_ready,
    output logic                 fb_ready
);
    logic            shift_p, le_p, sel_bit, ld_ref, ld_fb;
    logic [FB_W-1:0] ratio_sr, fb_raw;
    fb_word_t        fb_word;

    rise_det u_clk_edge (.clk(clk), .rst(rst), .lvl(ser_clk), .pulse(shift_p));
    rise_det u_le_edge  (.clk(clk), .rst(rst), .lvl(ser_le),  .pulse(le_p));

    frame_shifter #(.W(FB_W)) u_shift (
        .clk(clk), .rst(rst), .shift(shift_p), .din(ser_data),
        .ratio_sr(ratio_sr), .sel_bit(sel_bit)
    );

    assign ld_ref = le_p &  sel_bit;
    assign ld_fb  = le_p & ~sel_bit;

    ratio_hold #(.W(REF_W)) u_ref (
        .clk(clk), .rst(rst), .load(ld_ref), .d(ratio_sr[REF_W-1:0]),
        .q(ref_ratio), .ready(ref_ready)
    );

    ratio_hold #(.W(FB_W)) u_fb (
        .clk(clk), .rst(rst), .load(ld_fb), .d(ratio_sr),
        .q(fb_raw), .ready(fb_ready)
    );

    assign fb_word     = split_fb(fb_raw);
    assign swallow_cnt = fb_word.swallow;
    assign main_cnt    = fb_word.main;

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_ref, ld_fb})); // R4
    AST_REF_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        ld_fb |=> $stable(ref_ratio)); // R3
    AST_FB_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        ld_ref |=> $stable(swallow_cnt) && $stable(main_cnt)); // R4
endmodule

// File: tb/tb_serial_ratio_loader.sv
module tb_serial_ratio_loader;
    import ratio_pkg::*;

    logic clk = 1'b0;
    logic rst, ser_clk, ser_data, ser_le;
    logic [REF_W-1:0]     ref_ratio;
    logic [SWALLOW_W-1:0] swallow_cnt;
    logic [MAIN_W-1:0]    main_cnt;
    logic                 ref_ready, fb_ready;

    always #2.5 clk = ~clk;

    serial_ratio_loader dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .ref_ready(ref_ready), .fb_ready(fb_ready)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [FB_W:0]        hist = '0;
    logic [REF_W-1:0]     e_ref = '0;
    logic [SWALLOW_W-1:0] e_sw = '0;
    logic [MAIN_W-1:0]    e_mn = '0;
    logic                 e_rr = 0, e_fr = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "ref_ratio", 32'(ref_ratio), 32'(e_ref));
        chk(req, "swallow_cnt", 32'(swallow_cnt), 32'(e_sw));
        chk(req, "main_cnt", 32'(main_cnt), 32'(e_mn));
        chk(req, "ref_ready", 32'(ref_ready), 32'(e_rr));
        chk(req, "fb_ready", 32'(fb_ready), 32'(e_fr));
    endtask

    function automatic void model_latch(input logic [FB_W:0] h);
        if (h[0]) begin
            e_ref = h[REF_W:1];
            e_rr  = 1'b1;
        end else begin
            e_sw = h[FB_W:MAIN_W+1];
            e_mn = h[MAIN_W:1];
            e_fr = 1'b1;
        end
    endfunction

    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b1;
        hist     = {hist[FB_W-1:0], b};
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift_word(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        @(negedge clk);
        ser_le = 1'b1;
        model_latch(hist);
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; ser_clk = 0; ser_data = 0; ser_le = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_all("R1");

        // R4: reference frame, 14 bits then selector 1
        shift_word({14'h2A5C, 1'b1}, 15);
        strobe();
        chk_all("R4");
        chk("R5", "fb_ready after ref only", 32'(fb_ready), 32'd0);

        // R3: feedback frame, swallow then main then selector 0
        shift_word({6'h2D, 12'hB3E, 1'b0}, 19);
        strobe();
        chk_all("R3");
        chk("R5", "ref_ready still set", 32'(ref_ready), 32'd1);

        // R6: long frame with leading junk
        shift_word(32'hFFFF_FFFF, 11);
        shift_word({6'h05, 12'h123, 1'b0}, 19);
        strobe();
        chk_all("R6");

        // R7: strobe held high while a new frame arrives
        @(negedge clk);
        ser_le = 1'b1;
        model_latch(hist);
        repeat (3) @(negedge clk);
        chk_all("R7");
        shift_word({14'h0FF1, 1'b1}, 15);
        chk_all("R7");
        ser_le = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R7");

        // R9: shift and strobe on the same edge
        shift_word({6'h11, 12'h0A0}, 18);
        @(negedge clk);
        model_latch(hist);
        ser_data = 1'b0;
        ser_clk  = 1'b1;
        ser_le   = 1'b1;
        hist     = {hist[FB_W-1:0], 1'b0};
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        ser_le  = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R9");
        strobe();
        chk_all("R9");

        // Random frames, random lengths, with unlatched shifting in between
        for (int k = 0; k < 40; k++) begin
            int n;
            n = 8 + int'($urandom_range(0, 18));
            shift_word($urandom(), n);
            chk_all("R8");
            strobe();
            chk_all(hist[0] ? "R4" : "R3");
        end

        // R2: falling serial clock alone must not shift
        @(negedge clk);
        ser_clk = 1'b1; ser_data = 1'b1;
        hist = {hist[FB_W-1:0], 1'b1};
        repeat (2) @(negedge clk);
        ser_data = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        strobe();
        chk_all("R2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule